// File: doc/BRIEF.md
# Data-Capture Eye Search Controller

This block calibrates the sampling point of a wide source-synchronous parallel input. It owns three 4-bit delay codes. The first is the main sample delay. The other two are a setup probe delay and a hold probe delay, which feed a pair of auxiliary samplers. A single comparison flag (`checkOk`) is high while the auxiliary samplers still agree with the main sampler.

The controller finds the leading edge of the data window by walking the setup probe upward while the hold probe stays at zero. It then finds the trailing edge by walking the hold probe while the setup probe stays at zero. From the two margins it computes a centred sample delay. After every probe step it waits a fixed number of controller ticks before it reads the flag.

The controller logic advances on a tick derived from the fast clock. The tick period is set by a 4-bit predivider code. In manual mode the three delay codes come straight from the configuration inputs and the search is idle. In watch mode the search runs continuously and reports results but never moves the sample delay. In auto mode it also applies the new optimum, but only when the optimum differs from the current value by more than a 2-bit threshold.

Top module: `eye_search_ctrl`

## Requirements
- R1: After reset, with mode 0 and zero manual inputs, all delay outputs, `setupCount`, `holdCount`, `optimum`, `searchErr` and `passDone` are 0.
- R2: With `modeSel` = 0 (manual), `sampleDly`, `setupDly` and `holdDly` equal `manSample`, `manSetup` and `manHold` in the same cycle, and `passDone` never pulses.
- R3: In a pass, `setupCount` is the first setup probe code, counted upward from 0 with the hold probe at 0, at which `checkOk` is low. While the setup probe is nonzero, the hold probe is 0.
- R4: In a pass, `holdCount` is the first hold probe code, counted upward from 0 with the setup probe at 0, at which `checkOk` is low. While the hold probe is nonzero, the setup probe is 0.
- R5: If `checkOk` is still high at probe code 15 in either phase, that count saturates at 15 and `searchErr` is 1 for that pass; otherwise `searchErr` is 0. A drop exactly at code 15 is not an error.
- R6: `optimum` equals floor((`setupCount` + `holdCount`) / 2) and never exceeds 15.
- R7: With `modeSel` = 2 (auto), at the end of a pass `sampleDly` takes `optimum` only when |`optimum` − `sampleDly`| > `thresh`; otherwise `sampleDly` is unchanged.
- R8: With `modeSel` = 1 (watch), results update each pass while `sampleDly` keeps the value it had on leaving manual mode.
- R9: Each completed pass raises `passDone` for exactly one fast-clock cycle, and passes repeat back to back while a search mode is selected.
- R10: A controller tick occurs every 2^(4+`divCode`) fast clocks. Each probe step takes SETTLE_TICKS+2 ticks (default 4), so consecutive `passDone` pulses are ((`setupCount`+`holdCount`+2)·4+1)·2^(4+`divCode`) fast clocks apart.
- R11: `modeSel` = 3 behaves exactly as manual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divCode | input | 4 | Predivider code N, tick every 2^(4+N) clocks |
| modeSel | input | 2 | 0 manual, 1 watch, 2 auto, 3 manual |
| thresh | input | 2 | Minimum difference exceeded before auto apply |
| manSample | input | 4 | Manual sample delay |
| manSetup | input | 4 | Manual setup probe delay |
| manHold | input | 4 | Manual hold probe delay |
| checkOk | input | 1 | High while the auxiliary samplers agree with the main sampler |
| sampleDly | output | 4 | Sample delay code to the delay line |
| setupDly | output | 4 | Setup probe delay code |
| holdDly | output | 4 | Hold probe delay code |
| setupCount | output | 4 | Setup margin of the last pass |
| holdCount | output | 4 | Hold margin of the last pass |
| optimum | output | 4 | Centred sample delay of the last pass |
| searchErr | output | 1 | Last pass saturated a probe |
| passDone | output | 1 | One-cycle pulse at the end of each pass |

## Verification
The assertions assume that `checkOk` is a settled function of the current probe codes. The flag is high below an edge and low from the edge onward, so the window is monotone in each probe direction. They also assume that mode, threshold, predivider and manual values change only while manual mode is selected. The bench drives `checkOk` combinationally from a rectangular window model with a setup width and a hold width. It reprograms the window and all configuration only after switching to manual mode, so every pass it scores was run against one stable window.

// File: rtl/eye_search_pkg.sv
`timescale 1ns/1ps
package eye_search_pkg;

  localparam logic [1:0] MODE_MANUAL = 2'b00;
  localparam logic [1:0] MODE_WATCH  = 2'b01;
  localparam logic [1:0] MODE_AUTO   = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SET_SETTLE,
    S_SET_CHECK,
    S_HOLD_SETTLE,
    S_HOLD_CHECK,
    S_FINISH
  } eye_state_t;

  // strobes from the search control to the delay datapath
  typedef struct packed {
    logic probeClr;
    logic probeInc;
    logic settleLoad;
    logic settleDec;
    logic latchSetup;
    logic latchHold;
    logic flagErr;
    logic errClr;
    logic commit;
    logic applyOk;
    logic phaseSetup;
    logic phaseHold;
  } eye_strobe_t;

endpackage

// File: rtl/eye_tick_gen.sv
`timescale 1ns/1ps
module eye_tick_gen #(
  parameter int DIV_W      = 4,
  parameter int BASE_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divCode,
  output logic             tick
);

  localparam int CNT_W = BASE_SHIFT + (1 << DIV_W) - 1;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divMask;

  always_comb begin
    divMask = (CNT_W'(1) << (BASE_SHIFT + int'(divCode))) - CNT_W'(1);
    tick    = &(divCnt | ~divMask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else        divCnt <= divCnt + CNT_W'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R10

endmodule

// File: rtl/eye_search_fsm.sv
`timescale 1ns/1ps
module eye_search_fsm
  import eye_search_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        searchOn,
  input  logic        autoOn,
  input  logic        checkOk,
  input  logic        probeMax,
  input  logic        settleZero,
  output eye_strobe_t strb
);

  eye_state_t state;
  eye_state_t stateNxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state <= S_IDLE;
    else if (!searchOn) state <= S_IDLE;
    else if (tick)      state <= stateNxt;
  end

  always_comb begin
    strb            = '0;
    stateNxt        = state;
    strb.phaseSetup = (state == S_SET_SETTLE)  || (state == S_SET_CHECK);
    strb.phaseHold  = (state == S_HOLD_SETTLE) || (state == S_HOLD_CHECK);
    if (searchOn && tick) begin
      unique case (state)
        S_IDLE: begin
          strb.probeClr   = 1'b1;
          strb.settleLoad = 1'b1;
          strb.errClr     = 1'b1;
          stateNxt        = S_SET_SETTLE;
        end
        S_SET_SETTLE: begin
          if (settleZero) stateNxt = S_SET_CHECK;
          else            strb.settleDec = 1'b1;
        end
        S_SET_CHECK: begin
          strb.settleLoad = 1'b1;
          if (!checkOk || probeMax) begin
            strb.latchSetup = 1'b1;
            strb.flagErr    = checkOk;
            strb.probeClr   = 1'b1;
            stateNxt        = S_HOLD_SETTLE;
          end else begin
            strb.probeInc = 1'b1;
            stateNxt      = S_SET_SETTLE;
          end
        end
        S_HOLD_SETTLE: begin
          if (settleZero) stateNxt = S_HOLD_CHECK;
          else            strb.settleDec = 1'b1;
        end
        S_HOLD_CHECK: begin
          if (!checkOk || probeMax) begin
            strb.latchHold = 1'b1;
            strb.flagErr   = checkOk;
            strb.probeClr  = 1'b1;
            stateNxt       = S_FINISH;
          end else begin
            strb.probeInc   = 1'b1;
            strb.settleLoad = 1'b1;
            stateNxt        = S_HOLD_SETTLE;
          end
        end
        S_FINISH: begin
          strb.commit     = 1'b1;
          strb.applyOk    = autoOn;
          strb.probeClr   = 1'b1;
          strb.settleLoad = 1'b1;
          strb.errClr     = 1'b1;
          stateNxt        = S_SET_SETTLE;
        end
        default: stateNxt = S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eye_delay_path.sv
`timescale 1ns/1ps
module eye_delay_path
  import eye_search_pkg::*;
#(
  parameter int DLY_W        = 4,
  parameter int TH_W         = 2,
  parameter int SETTLE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  eye_strobe_t      strb,
  input  logic             searchOn,
  input  logic [DLY_W-1:0] manSample,
  input  logic [DLY_W-1:0] manSetup,
  input  logic [DLY_W-1:0] manHold,
  input  logic [TH_W-1:0]  thresh,
  output logic             probeMax,
  output logic             settleZero,
  output logic [DLY_W-1:0] sampleDly,
  output logic [DLY_W-1:0] setupDly,
  output logic [DLY_W-1:0] holdDly,
  output logic [DLY_W-1:0] setupRes,
  output logic [DLY_W-1:0] holdRes,
  output logic [DLY_W-1:0] optRes,
  output logic             errRes,
  output logic             done
);

  localparam int SET_W = (SETTLE_TICKS < 1) ? 1 : $clog2(SETTLE_TICKS + 1);

  logic [DLY_W-1:0] probe;
  logic [SET_W-1:0] settleCnt;
  logic [DLY_W-1:0] setupWork;
  logic [DLY_W-1:0] holdWork;
  logic             pendErr;
  logic [DLY_W-1:0] sampleQ;
  logic [DLY_W:0]   sumW;
  logic [DLY_W-1:0] halfW;
  logic [DLY_W-1:0] diffW;
  logic             farEnough;

  always_comb begin
    probeMax   = (probe == {DLY_W{1'b1}});
    settleZero = (settleCnt == '0);
    sumW       = {1'b0, setupWork} + {1'b0, holdWork};
    halfW      = DLY_W'(sumW >> 1);
    diffW      = (halfW > sampleQ) ? (halfW - sampleQ) : (sampleQ - halfW);
    farEnough  = (int'(diffW) > int'(thresh));
  end

  // probe code and settle timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      probe     <= '0;
      settleCnt <= '0;
    end else begin
      if (strb.probeClr)      probe <= '0;
      else if (strb.probeInc) probe <= probe + DLY_W'(1);
      if (strb.settleLoad)     settleCnt <= SET_W'(SETTLE_TICKS);
      else if (strb.settleDec) settleCnt <= settleCnt - SET_W'(1);
    end
  end

  // margins of the pass in progress
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setupWork <= '0;
      holdWork  <= '0;
      pendErr   <= 1'b0;
    end else begin
      if (strb.latchSetup) setupWork <= probe;
      if (strb.latchHold)  holdWork  <= probe;
      if (strb.errClr)       pendErr <= 1'b0;
      else if (strb.flagErr) pendErr <= 1'b1;
    end
  end

  // committed results and done pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setupRes <= '0;
      holdRes  <= '0;
      optRes   <= '0;
      errRes   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= strb.commit;
      if (strb.commit) begin
        setupRes <= setupWork;
        holdRes  <= holdWork;
        optRes   <= halfW;
        errRes   <= pendErr;
      end
    end
  end

  // main sample delay register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         sampleQ <= '0;
    else if (!searchOn)                 sampleQ <= manSample;
    else if (strb.applyOk && farEnough) sampleQ <= halfW;
  end

  always_comb begin
    sampleDly = searchOn ? sampleQ : manSample;
    setupDly  = searchOn ? (strb.phaseSetup ? probe : '0) : manSetup;
    holdDly   = searchOn ? (strb.phaseHold  ? probe : '0) : manHold;
  end

  AST_ERR_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && errRes) |-> (setupRes == {DLY_W{1'b1}} || holdRes == {DLY_W{1'b1}})); // R5
  AST_OPT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (optRes <= ((setupRes > holdRes) ? setupRes : holdRes)
           && optRes >= ((setupRes > holdRes) ? holdRes : setupRes))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

// File: rtl/eye_search_ctrl.sv
`timescale 1ns/1ps
module eye_search_ctrl #(
  parameter int DLY_W        = 4,
  parameter int DIV_W        = 4,
  parameter int BASE_SHIFT   = 4,
  parameter int TH_W         = 2,
  parameter int SETTLE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divCode,
  input  logic [1:0]       modeSel,
  input  logic [TH_W-1:0]  thresh,
  input  logic [DLY_W-1:0] manSample,
  input  logic [DLY_W-1:0] manSetup,
  input  logic [DLY_W-1:0] manHold,
  input  logic             checkOk,
  output logic [DLY_W-1:0] sampleDly,
  output logic [DLY_W-1:0] setupDly,
  output logic [DLY_W-1:0] holdDly,
  output logic [DLY_W-1:0] setupCount,
  output logic [DLY_W-1:0] holdCount,
  output logic [DLY_W-1:0] optimum,
  output logic             searchErr,
  output logic             passDone
);

  logic tick;
  logic searchOn;
  logic autoOn;
  logic probeMax;
  logic settleZero;
  eye_search_pkg::eye_strobe_t strb;

  assign searchOn = (modeSel == eye_search_pkg::MODE_WATCH) || (modeSel == eye_search_pkg::MODE_AUTO);
  assign autoOn   = (modeSel == eye_search_pkg::MODE_AUTO);

  eye_tick_gen #(.DIV_W(DIV_W), .BASE_SHIFT(BASE_SHIFT)) u_tick (
    .clk(clk), .rst_n(rst_n), .divCode(divCode), .tick(tick)
  );

  eye_search_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .searchOn(searchOn), .autoOn(autoOn),
    .checkOk(checkOk), .probeMax(probeMax), .settleZero(settleZero), .strb(strb)
  );

  eye_delay_path #(.DLY_W(DLY_W), .TH_W(TH_W), .SETTLE_TICKS(SETTLE_TICKS)) u_path (
    .clk(clk), .rst_n(rst_n), .strb(strb), .searchOn(searchOn),
    .manSample(manSample), .manSetup(manSetup), .manHold(manHold), .thresh(thresh),
    .probeMax(probeMax), .settleZero(settleZero),
    .sampleDly(sampleDly), .setupDly(setupDly), .holdDly(holdDly),
    .setupRes(setupCount), .holdRes(holdCount), .optRes(optimum),
    .errRes(searchErr), .done(passDone)
  );

  AST_NO_DONE_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !searchOn |=> !passDone); // R2
  AST_PROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    searchOn |-> !(setupDly != '0 && holdDly != '0)); // R3
  AST_WATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == eye_search_pkg::MODE_WATCH && $past(modeSel) == eye_search_pkg::MODE_WATCH)
      |-> $stable(sampleDly)); // R8
  AST_AUTO_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == eye_search_pkg::MODE_AUTO && $past(modeSel) == eye_search_pkg::MODE_AUTO
     && sampleDly != $past(sampleDly)) |-> (passDone && sampleDly == optimum)); // R7

endmodule

// File: tb/eye_search_ctrl_tb.sv
`timescale 1ns/1ps
module eye_search_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] divCode = '0;
  logic [1:0] modeSel = '0;
  logic [1:0] thresh = '0;
  logic [3:0] manSample = '0, manSetup = '0, manHold = '0;
  logic       checkOk;
  logic [3:0] sampleDly, setupDly, holdDly, setupCount, holdCount, optimum;
  logic       searchErr, passDone;

  int eyeS = 8, eyeH = 8;
  int ntests = 0, nfail = 0;
  int doneCount = 0, cyc = 0, lastDone = 0, lastInterval = 0, expSample = 0;
  bit monOn = 0, prevDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // rectangular data window seen by the auxiliary samplers
  assign checkOk = (int'(setupDly) < eyeS) && (int'(holdDly) < eyeH);

  eye_search_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .divCode(divCode), .modeSel(modeSel), .thresh(thresh),
    .manSample(manSample), .manSetup(manSetup), .manHold(manHold), .checkOk(checkOk),
    .sampleDly(sampleDly), .setupDly(setupDly), .holdDly(holdDly),
    .setupCount(setupCount), .holdCount(holdCount), .optimum(optimum),
    .searchErr(searchErr), .passDone(passDone)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // first probe code at which the window model reports disagreement
  function automatic int firstDrop(input bit setupSide, output bit sat);
    for (int p = 0; p < 16; p++) begin
      bit ok;
      ok = setupSide ? (p < eyeS && 0 < eyeH) : (0 < eyeS && p < eyeH);
      if (!ok) begin
        sat = 1'b0;
        return p;
      end
    end
    sat = 1'b1;
    return 15;
  endfunction

  always @(posedge clk) cyc++;

  // reference model, evaluated every clock
  always @(negedge clk) begin
    if (monOn) begin
      if (modeSel == 2'b00 || modeSel == 2'b11) begin
        expSample = int'(manSample);
        chk(sampleDly == manSample && setupDly == manSetup && holdDly == manHold,
            "R2 R11 manual passthrough", int'(sampleDly), int'(manSample));
        chk(!passDone, "R2 R11 no pass in manual", int'(passDone), 0);
      end else begin
        if (passDone) begin
          bit sS, sH;
          int sc, hc, op, d;
          sc = firstDrop(1'b1, sS);
          hc = firstDrop(1'b0, sH);
          op = (sc + hc) / 2;
          chk(int'(setupCount) == sc, "R3 setup count", int'(setupCount), sc);
          chk(int'(holdCount) == hc, "R4 hold count", int'(holdCount), hc);
          chk(int'(optimum) == op, "R6 optimum", int'(optimum), op);
          chk(searchErr == (sS || sH), "R5 error flag", int'(searchErr), int'(sS || sH));
          if (modeSel == 2'b10) begin
            d = op - expSample;
            if (d < 0) d = -d;
            if (d > int'(thresh)) expSample = op;
          end
          doneCount++;
          lastInterval = cyc - lastDone;
          lastDone = cyc;
        end
        chk(int'(sampleDly) == expSample, (modeSel == 2'b10) ? "R7 sample delay" : "R8 sample delay",
            int'(sampleDly), expSample);
        chk(!(setupDly != 0 && holdDly != 0), "R3 R4 probe exclusivity",
            int'(setupDly) * 16 + int'(holdDly), 0);
      end
      chk(!(passDone && prevDone), "R9 single-cycle done", 2, 1);
      prevDone = passDone;
    end
  end

  task automatic waitDones(input int n);
    int target, guard;
    target = doneCount + n;
    guard = 0;
    while (doneCount < target && guard < 20000) begin
      @(posedge clk);
      guard++;
    end
    if (doneCount < target) chk(1'b0, "R9 pass timeout", doneCount, target);
    @(negedge clk);
  endtask

  task automatic runMode(input logic [1:0] m, input int s, input int h, input logic [1:0] th,
                         input logic [3:0] ms, input logic [3:0] dc);
    @(posedge clk); #1;
    modeSel = 2'b00; manSample = ms; thresh = th; divCode = dc; eyeS = s; eyeH = h;
    @(posedge clk); #1;
    modeSel = m;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nfail++; ntests++;
    $display("FAIL R9 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sampleDly == 0 && setupDly == 0 && holdDly == 0, "R1 reset delays", int'(sampleDly), 0);
    chk(setupCount == 0 && holdCount == 0 && optimum == 0, "R1 reset results", int'(optimum), 0);
    chk(!searchErr && !passDone, "R1 reset flags", int'(searchErr), 0);
    monOn = 1;

    // R2 manual mode
    @(posedge clk); #1;
    manSample = 4'd5; manSetup = 4'd9; manHold = 4'd3;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(setupDly == 9 && holdDly == 3 && sampleDly == 5, "R2 manual values", int'(setupDly), 9);
    // R11 mode 3 acts as manual
    @(posedge clk); #1 modeSel = 2'b11; manSetup = 4'd12;
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk(setupDly == 12 && doneCount == 0, "R11 mode 3 manual", int'(setupDly), 12);

    // R7 auto centring, R10 pass period at divide-by-16
    runMode(2'b10, 6, 10, 2'd0, 4'd5, 4'd0);
    waitDones(2);
    chk(lastInterval == 1168, "R10 period code 0", lastInterval, 1168);
    chk(sampleDly == 8, "R7 applied optimum", int'(sampleDly), 8);
    chk(setupCount == 6 && holdCount == 10, "R3 R4 margins", int'(setupCount), 6);

    // R10 divide-by-32
    runMode(2'b10, 6, 10, 2'd0, 4'd5, 4'd1);
    waitDones(2);
    chk(lastInterval == 2336, "R10 period code 1", lastInterval, 2336);

    // R7 threshold not exceeded, then exceeded
    runMode(2'b10, 6, 14, 2'd3, 4'd8, 4'd0);
    waitDones(1);
    chk(sampleDly == 8 && optimum == 10, "R7 within threshold kept", int'(sampleDly), 8);
    runMode(2'b10, 10, 14, 2'd3, 4'd8, 4'd0);
    waitDones(1);
    chk(sampleDly == 12, "R7 beyond threshold applied", int'(sampleDly), 12);

    // R8 watch mode leaves the sample delay alone
    runMode(2'b01, 2, 4, 2'd0, 4'd11, 4'd0);
    waitDones(2);
    chk(sampleDly == 11 && optimum == 3, "R8 watch keeps sample", int'(sampleDly), 11);

    // R5 saturation on either side, and a drop exactly at code 15
    runMode(2'b10, 20, 5, 2'd0, 4'd0, 4'd0);
    waitDones(1);
    chk(setupCount == 15 && searchErr && optimum == 10, "R5 setup saturates", int'(setupCount), 15);
    runMode(2'b10, 4, 30, 2'd0, 4'd0, 4'd0);
    waitDones(1);
    chk(holdCount == 15 && searchErr, "R5 hold saturates", int'(holdCount), 15);
    runMode(2'b10, 15, 15, 2'd0, 4'd0, 4'd0);
    waitDones(1);
    chk(!searchErr && optimum == 15, "R5 R6 drop at 15 no error", int'(searchErr), 0);

    // R6 closed window
    runMode(2'b10, 0, 0, 2'd0, 4'd9, 4'd0);
    waitDones(2);
    chk(optimum == 0 && sampleDly == 0, "R6 closed window", int'(optimum), 0);

    @(posedge clk); #1 modeSel = 2'b00;
    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule